// File: doc/BRIEF.md
# ADC Start-of-Conversion Sequencer

This block sets the timing of a multi-channel analog-to-digital converter. It holds a number of conversion slots. Each slot names one of the trigger inputs and carries its own acquisition length. A pulse on a trigger input makes every slot routed to it pending. A rotating arbiter then serves the pending slots one at a time. For each granted slot the block opens a sample-and-hold window (`sample_o`) of acquisition length plus one cycles. After the window it counts the converter latency, and then captures the converter's digital word into that slot's result register.

Two resolution modes are available. In the high-resolution mode, the next window opens on the same edge on which the previous result is captured. In the fast mode the next window may open before the capture, so sampling overlaps the tail of the conversion. Each interrupt flag watches one selected slot. A mode bit places the flag either at the end of the window or at the result capture. Software clears a flag with a write-one strobe. A trigger that hits a slot that is still pending is not queued twice, and a sticky per-slot overflow bit records it.

Top module: `adc_soc_sequencer`

## Requirements
- R1: For a granted slot, `sample_o` stays high for exactly (acquisition + 1) consecutive cycles, with `sample_slot_o` naming that slot. The acquisition value is the slot's field in `slot_acq_i`, bits [s*ACQ_W +: ACQ_W].
- R2: A trigger input that is high at a clock edge sets `pending_o` for every slot whose `slot_trig_sel_i` field (bits [s*TSEL_W +: TSEL_W]) holds that input's index. The change is visible after that edge. When the sequencer is idle, the window of the served slot opens on the next edge.
- R3: Arbitration starts searching at the slot one above the slot granted last, wrapping at the top. After reset the first slot searched is slot 0.
- R4: With `mode16_i`=1, the result is captured LAT16 (default 29) edges after the window-end edge. A further pending slot's window opens on that same edge.
- R5: With `mode16_i`=0, the result is captured LAT12 (default 10) edges after the window-end edge. A further pending slot's window opens NEXT12 (default 7) edges after the window-end edge.
- R6: `rd_data_o` returns the result register of slot `rd_slot_i`. The register resets to zero and holds its previous value until the capture edge.
- R7: With `int_at_latch_i`=0, flag k is set on the edge that ends the window of the slot given by field k of `int_slot_sel_i` (bits [k*SLOT_W +: SLOT_W]).
- R8: With `int_at_latch_i`=1, flag k is set on the edge that captures the selected slot's result.
- R9: A flag is never set by the end of conversion of a slot other than its selected slot.
- R10: A flag stays set until a one on its `int_clr_i` bit. If a set and a clear fall on the same edge, the flag ends up set.
- R11: A trigger that hits a slot that is still pending (and not being granted on that edge) is not queued again. It sets that slot's sticky `overflow_o` bit, which a one on the matching `ovf_clr_i` bit clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trig_i | input | NUM_TRIG | Trigger pulses |
| slot_trig_sel_i | input | NUM_SLOTS*TSEL_W | Trigger index per slot |
| slot_acq_i | input | NUM_SLOTS*ACQ_W | Acquisition length per slot |
| mode16_i | input | 1 | 1: high-resolution timing, 0: fast timing |
| int_at_latch_i | input | 1 | 1: flag at result capture, 0: flag at window end |
| int_slot_sel_i | input | NUM_INT*SLOT_W | Slot watched by each flag |
| int_clr_i | input | NUM_INT | Write-one-to-clear strobes for flags |
| ovf_clr_i | input | NUM_SLOTS | Write-one-to-clear strobes for overflow bits |
| conv_data_i | input | DATA_W | Digital word from the converter |
| rd_slot_i | input | SLOT_W | Result register select |
| rd_data_o | output | DATA_W | Selected result register |
| sample_o | output | 1 | Sample-and-hold window active |
| sample_slot_o | output | SLOT_W | Slot in the current window |
| pending_o | output | NUM_SLOTS | Pending slots |
| overflow_o | output | NUM_SLOTS | Sticky retrigger overflow bits |
| int_flag_o | output | NUM_INT | Interrupt flags |

## Verification
Count edges from the trigger edge P0. Pending is due after P0. The window opens after P1 and closes after P(acq+2), which is the window-end edge E. The result is due after E+LAT, and a flag after either E or E+LAT. The next window of a queued slot opens after E+NEXT. The bench drives and samples on falling edges, logs the first falling-edge index at which each output takes its new value, and compares that index with the count above. It also reads the result register one cycle before the capture to confirm that the old value is still held.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SAMPLE,
    ST_GAP
  } seq_state_e;
endpackage

// File: rtl/adc_seq_arbiter.sv
module adc_seq_arbiter #(
  parameter int NUM_SLOTS = 8,
  localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic [NUM_SLOTS-1:0] pend_i,
  input  logic [SLOT_W-1:0]    ptr_i,
  output logic                 vld_o,
  output logic [SLOT_W-1:0]    idx_o
);
  // highest offset first so the nearest slot above ptr wins
  always_comb begin
    vld_o = 1'b0;
    idx_o = '0;
    for (int off = NUM_SLOTS; off >= 1; off--) begin
      int c;
      c = int'(ptr_i) + off;
      if (c >= NUM_SLOTS) c = c - NUM_SLOTS;
      if (pend_i[c]) begin
        vld_o = 1'b1;
        idx_o = SLOT_W'(c);
      end
    end
  end

  always_comb begin
    assert_grant_pending_R3: assert (!vld_o || pend_i[idx_o]);
  end
endmodule

// File: rtl/adc_seq_latency.sv
module adc_seq_latency #(
  parameter int SLOT_W = 3,
  parameter int LAT12  = 10,
  parameter int LAT16  = 29,
  localparam int DEPTH = (LAT16 > LAT12) ? LAT16 : LAT12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic              mode16_i,
  output logic              pop_o,
  output logic [SLOT_W-1:0] pop_slot_o,
  output logic              busy_o
);
  logic [DEPTH-1:0]  v_q;
  logic [SLOT_W-1:0] s_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_q <= '0;
      for (int j = 0; j < DEPTH; j++) s_q[j] <= '0;
    end else begin
      v_q[0] <= push_i;
      s_q[0] <= slot_i;
      for (int j = 1; j < DEPTH; j++) begin
        v_q[j] <= v_q[j-1];
        s_q[j] <= s_q[j-1];
      end
    end
  end

  assign pop_o      = mode16_i ? v_q[LAT16-1] : v_q[LAT12-1];
  assign pop_slot_o = mode16_i ? s_q[LAT16-1] : s_q[LAT12-1];
  assign busy_o     = |v_q;

  assert_pop_had_push_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |=> busy_o);
endmodule

// File: rtl/adc_seq_intflag.sv
module adc_seq_intflag #(
  parameter int NUM_INT = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_INT-1:0] set_i,
  input  logic [NUM_INT-1:0] clr_i,
  output logic [NUM_INT-1:0] flag_o
);
  logic [NUM_INT-1:0] flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= '0;
    else         flag_q <= (flag_q & ~clr_i) | set_i;
  end

  assign flag_o = flag_q;

  for (genvar k = 0; k < NUM_INT; k++) begin : g_chk
    assert_set_wins_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[k] |=> flag_o[k]);
    assert_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[k] && !set_i[k]) |=> !flag_o[k]);
  end
endmodule

// File: rtl/adc_soc_sequencer.sv
module adc_soc_sequencer
  import adc_seq_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  parameter int NUM_TRIG  = 4,
  parameter int NUM_INT   = 2,
  parameter int ACQ_W     = 6,
  parameter int DATA_W    = 16,
  parameter int LAT12     = 10,
  parameter int NEXT12    = 7,
  parameter int LAT16     = 29,
  parameter int NEXT16    = 29,
  localparam int SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
  localparam int TSEL_W   = (NUM_TRIG > 1) ? $clog2(NUM_TRIG) : 1,
  localparam int NEXT_MAX = (NEXT16 > NEXT12) ? NEXT16 : NEXT12,
  localparam int GAP_W    = $clog2(NEXT_MAX + 1)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [NUM_TRIG-1:0]         trig_i,
  input  logic [NUM_SLOTS*TSEL_W-1:0] slot_trig_sel_i,
  input  logic [NUM_SLOTS*ACQ_W-1:0]  slot_acq_i,
  input  logic                        mode16_i,
  input  logic                        int_at_latch_i,
  input  logic [NUM_INT*SLOT_W-1:0]   int_slot_sel_i,
  input  logic [NUM_INT-1:0]          int_clr_i,
  input  logic [NUM_SLOTS-1:0]        ovf_clr_i,
  input  logic [DATA_W-1:0]           conv_data_i,
  input  logic [SLOT_W-1:0]           rd_slot_i,
  output logic [DATA_W-1:0]           rd_data_o,
  output logic                        sample_o,
  output logic [SLOT_W-1:0]           sample_slot_o,
  output logic [NUM_SLOTS-1:0]        pending_o,
  output logic [NUM_SLOTS-1:0]        overflow_o,
  output logic [NUM_INT-1:0]          int_flag_o
);
  seq_state_e         state_q;
  logic [ACQ_W-1:0]   cnt_q, cur_acq_q, win_len_q;
  logic [GAP_W-1:0]   gap_q;
  logic [SLOT_W-1:0]  slot_q, ptr_q, grant_idx, pop_slot;
  logic [NUM_SLOTS-1:0] pend_q, ovf_q, hit, grant_oh;
  logic               grant_vld, ready, do_grant, win_end, pop, lat_busy;
  logic [NUM_INT-1:0] int_set;
  logic [DATA_W-1:0]  res_q [NUM_SLOTS];

  // trigger capture
  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_hit
    assign hit[s] = trig_i[slot_trig_sel_i[s*TSEL_W +: TSEL_W]];
  end

  adc_seq_arbiter #(.NUM_SLOTS(NUM_SLOTS)) u_arb (
    .pend_i (pend_q),
    .ptr_i  (ptr_q),
    .vld_o  (grant_vld),
    .idx_o  (grant_idx)
  );

  assign ready    = (state_q == ST_IDLE) || (state_q == ST_GAP && gap_q == '0);
  assign do_grant = ready && grant_vld;
  assign win_end  = (state_q == ST_SAMPLE) && (cnt_q == '0);
  assign grant_oh = do_grant ? (NUM_SLOTS'(1) << grant_idx) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      ovf_q  <= '0;
    end else begin
      pend_q <= (pend_q & ~grant_oh) | hit;
      ovf_q  <= (ovf_q & ~ovf_clr_i) | (hit & pend_q & ~grant_oh);
    end
  end

  // window / gap sequencing
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      cur_acq_q <= '0;
      gap_q     <= '0;
      slot_q    <= '0;
      ptr_q     <= SLOT_W'(NUM_SLOTS - 1);
    end else if (do_grant) begin
      state_q   <= ST_SAMPLE;
      cnt_q     <= slot_acq_i[grant_idx*ACQ_W +: ACQ_W];
      cur_acq_q <= slot_acq_i[grant_idx*ACQ_W +: ACQ_W];
      slot_q    <= grant_idx;
      ptr_q     <= grant_idx;
    end else begin
      case (state_q)
        ST_SAMPLE: begin
          if (cnt_q == '0) begin
            state_q <= ST_GAP;
            gap_q   <= mode16_i ? GAP_W'(NEXT16 - 1) : GAP_W'(NEXT12 - 1);
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        ST_GAP: begin
          if (gap_q != '0) gap_q   <= gap_q - 1'b1;
          else             state_q <= ST_IDLE;
        end
        default: ;
      endcase
    end
  end

  adc_seq_latency #(.SLOT_W(SLOT_W), .LAT12(LAT12), .LAT16(LAT16)) u_lat (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (win_end),
    .slot_i     (slot_q),
    .mode16_i   (mode16_i),
    .pop_o      (pop),
    .pop_slot_o (pop_slot),
    .busy_o     (lat_busy)
  );

  // result bank
  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_res
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          res_q[s] <= '0;
      else if (pop && pop_slot == SLOT_W'(s)) res_q[s] <= conv_data_i;
    end
    assert_result_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(pop && pop_slot == SLOT_W'(s)) |=> $stable(res_q[s]));
  end

  // interrupt set sources
  for (genvar k = 0; k < NUM_INT; k++) begin : g_int
    logic [SLOT_W-1:0] isel;
    assign isel = int_slot_sel_i[k*SLOT_W +: SLOT_W];
    assign int_set[k] = (!int_at_latch_i && win_end && slot_q == isel) ||
                        ( int_at_latch_i && pop && pop_slot == isel);
  end

  adc_seq_intflag #(.NUM_INT(NUM_INT)) u_int (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (int_set),
    .clr_i  (int_clr_i),
    .flag_o (int_flag_o)
  );

  assign rd_data_o     = res_q[rd_slot_i];
  assign sample_o      = (state_q == ST_SAMPLE);
  assign sample_slot_o = slot_q;
  assign pending_o     = pend_q;
  assign overflow_o    = ovf_q;

  // window length checker
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       win_len_q <= '0;
    else if (do_grant) win_len_q <= '0;
    else if (sample_o) win_len_q <= win_len_q + 1'b1;
  end

  assert_window_len_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_end |-> (win_len_q == cur_acq_q));

  assert_start16_drained_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (do_grant && state_q == ST_GAP && mode16_i && $stable(mode16_i)) |=> !lat_busy);

  assert_start12_overlap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (do_grant && state_q == ST_GAP && !mode16_i && (NEXT12 < LAT12)) |-> lat_busy);

  assert_no_overflow_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((ovf_q & ~$past(ovf_q) & ~$past(pend_q)) == '0));

  assert_no_double_grant_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    do_grant |=> !do_grant);
endmodule

// File: tb/adc_soc_sequencer_test.sv
`timescale 1ns/1ps
module adc_soc_sequencer_test;
  localparam int NS = 8, NT = 4, NI = 2, AW = 6, DW = 16, SW = 3, TW = 2;

  typedef struct packed {
    logic [2:0]  slot;
    logic        m16;
    logic        pos;
    logic [5:0]  acq;
    logic [15:0] data;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{3'd0, 1'b0, 1'b0, 6'd0,  16'h0A11},
    '{3'd2, 1'b0, 1'b1, 6'd5,  16'h1B22},
    '{3'd3, 1'b1, 1'b0, 6'd3,  16'h2C33},
    '{3'd3, 1'b1, 1'b1, 6'd12, 16'h3D44},
    '{3'd6, 1'b0, 1'b1, 6'd63, 16'h4E55},
    '{3'd4, 1'b1, 1'b1, 6'd1,  16'h5F66}
  };

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n;
  logic [NT-1:0] trig;
  logic [TW-1:0] sel [NS];
  logic [AW-1:0] acq [NS];
  logic [SW-1:0] isel [NI];
  logic [NS*TW-1:0] sel_flat;
  logic [NS*AW-1:0] acq_flat;
  logic [NI*SW-1:0] isel_flat;
  logic m16, ipos;
  logic [NI-1:0] iclr;
  logic [NS-1:0] oclr;
  logic [DW-1:0] cdata, rdata;
  logic [SW-1:0] rslot, sslot;
  logic samp;
  logic [NS-1:0] pend, ovf;
  logic [NI-1:0] iflag;

  always_comb begin
    for (int i = 0; i < NS; i++) begin
      sel_flat[i*TW +: TW] = sel[i];
      acq_flat[i*AW +: AW] = acq[i];
    end
    for (int k = 0; k < NI; k++) isel_flat[k*SW +: SW] = isel[k];
  end

  adc_soc_sequencer uut (
    .clk_i(clk), .rst_ni(rst_n), .trig_i(trig), .slot_trig_sel_i(sel_flat),
    .slot_acq_i(acq_flat), .mode16_i(m16), .int_at_latch_i(ipos),
    .int_slot_sel_i(isel_flat), .int_clr_i(iclr), .ovf_clr_i(oclr),
    .conv_data_i(cdata), .rd_slot_i(rslot), .rd_data_o(rdata),
    .sample_o(samp), .sample_slot_o(sslot), .pending_o(pend),
    .overflow_o(ovf), .int_flag_o(iflag)
  );

  int checks = 0, errors = 0;
  int st [8], en [8], sl [8];
  int nst, nen;
  logic [DW-1:0] last_res [NS];
  logic [DW-1:0] hist [128];

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic route(input logic [NS-1:0] mask, input int t);
    for (int i = 0; i < NS; i++) sel[i] = mask[i] ? TW'(t) : TW'(3);
  endtask

  task automatic pulse_trig(input int t);
    @(negedge clk) trig[t] = 1'b1;
    @(negedge clk) trig = '0;
  endtask

  task automatic clear_flags();
    @(negedge clk) iclr = '1;
    @(negedge clk) iclr = '0;
  endtask

  task automatic run_multi(input int ncyc);
    logic prev = 1'b0;
    nst = 0; nen = 0;
    for (int k = 1; k <= ncyc; k++) begin
      @(negedge clk);
      if (samp && !prev && nst < 8) begin st[nst] = k; sl[nst] = int'(sslot); nst++; end
      if (!samp && prev && nen < 8) begin en[nen] = k; nen++; end
      prev = samp;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; trig = '0; m16 = 1'b0; ipos = 1'b0; iclr = '0; oclr = '0;
    cdata = '0; rslot = '0;
    for (int i = 0; i < NS; i++) begin sel[i] = TW'(3); acq[i] = '0; last_res[i] = '0; end
    for (int k = 0; k < NI; k++) isel[k] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state
    check("R1 reset sample", 32'(samp), 0);
    check("R2 reset pending", 32'(pend), 0);
    check("R10 reset flags", 32'(iflag), 0);
    check("R11 reset overflow", 32'(ovf), 0);
    check("R6 reset result", 32'(rdata), 0);

    // R3: first grant after reset is slot 0; R5 overlap gap
    route(8'b0010_0001, 1); acq[0] = 6'd2; acq[5] = 6'd2; m16 = 1'b0;
    pulse_trig(1);
    check("R2 shared trigger pending", 32'(pend), 32'h21);
    run_multi(100);
    check("R3 count after reset", nst, 2);
    check("R3 first slot after reset", sl[0], 0);
    check("R3 second slot after reset", sl[1], 5);
    check("R5 next window 12-bit", st[1] - en[0], 7);

    // vector table: single-slot conversions
    for (int v = 0; v < 6; v++) begin
      vec_t t;
      int ws, we, tl, ti, exp_lat;
      logic seen1;
      t = VEC[v];
      route(8'(1) << t.slot, 0);
      acq[t.slot] = t.acq; m16 = t.m16; ipos = t.pos;
      isel[0] = t.slot; isel[1] = t.slot + 3'd1;
      cdata = t.data; rslot = t.slot;
      clear_flags();
      pulse_trig(0);
      check("R2 pending after trigger", 32'(pend[t.slot]), 1);
      ws = -1; we = -1; tl = -1; ti = -1; seen1 = 1'b0;
      for (int k = 1; k < 128; k++) begin
        @(negedge clk);
        hist[k] = rdata;
        if (samp && ws < 0) begin
          ws = k;
          check("R1 window slot", 32'(sslot), 32'(t.slot));
        end
        if (!samp && ws >= 0 && we < 0) we = k;
        if (rdata == t.data && tl < 0) tl = k;
        if (iflag[0] && ti < 0) ti = k;
        if (iflag[1]) seen1 = 1'b1;
      end
      exp_lat = (t.m16 ? 29 : 10) + int'(t.acq) + 2;
      check("R2 window start", ws, 1);
      check("R1 window length", we - ws, int'(t.acq) + 1);
      check(t.m16 ? "R4 latch time" : "R5 latch time", tl, exp_lat);
      check("R6 old value before latch", 32'(hist[exp_lat - 1]), 32'(last_res[t.slot]));
      check(t.pos ? "R8 flag at latch" : "R7 flag at window end", ti, t.pos ? exp_lat : int'(t.acq) + 2);
      check("R9 unselected flag", 32'(seen1), 0);
      last_res[t.slot] = t.data;
    end

    // R3 rotation from last granted slot 4
    route(8'b0010_1010, 1); acq[1] = 6'd1; acq[3] = 6'd4; acq[5] = 6'd0; m16 = 1'b0;
    pulse_trig(1);
    run_multi(120);
    check("R3 rotation count", nst, 3);
    check("R3 rotation first", sl[0], 5);
    check("R3 rotation second", sl[1], 1);
    check("R3 rotation third", sl[2], 3);

    // R4 back-to-back in 16-bit mode from last slot 3
    route(8'b0100_0100, 2); acq[2] = 6'd2; acq[6] = 6'd4; m16 = 1'b1;
    pulse_trig(2);
    run_multi(150);
    check("R4 order first", sl[0], 6);
    check("R4 order second", sl[1], 2);
    check("R4 next window 16-bit", st[1] - en[0], 29);

    // R10 set wins over clear
    route(8'b1000_0000, 2); acq[7] = 6'd4; m16 = 1'b0; ipos = 1'b0;
    isel[0] = 3'd7; isel[1] = 3'd0;
    clear_flags();
    pulse_trig(2);
    for (int k = 1; k <= 5; k++) @(negedge clk);
    iclr[0] = 1'b1;
    @(negedge clk);
    check("R10 set wins over clear", 32'(iflag[0]), 1);
    @(negedge clk);
    check("R10 clear strobe", 32'(iflag[0]), 0);
    iclr = '0;
    repeat (40) @(negedge clk);

    // R11 retrigger overflow
    route(8'b0000_0010, 2); acq[1] = 6'd3;
    @(negedge clk) trig[2] = 1'b1;
    @(negedge clk);
    check("R11 pending set", 32'(pend[1]), 1);
    @(negedge clk);
    check("R11 no overflow on grant edge", 32'(ovf[1]), 0);
    check("R11 requeued after grant", 32'(pend[1]), 1);
    @(negedge clk) trig = '0;
    check("R11 overflow set", 32'(ovf[1]), 1);
    begin
      int starts;
      logic prev;
      starts = 1; prev = samp;
      for (int k = 0; k < 100; k++) begin
        @(negedge clk);
        if (samp && !prev) starts++;
        prev = samp;
      end
      check("R11 conversions not doubled", starts, 2);
    end
    check("R11 overflow sticky", 32'(ovf[1]), 1);
    @(negedge clk) oclr[1] = 1'b1;
    @(negedge clk) oclr = '0;
    check("R11 overflow cleared", 32'(ovf[1]), 0);
    check("R11 pending drained", 32'(pend), 0);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule